// File: doc/BRIEF.md
# Video Input Sync and Field Decoder

This block sits at the entry of a parallel video capture port and runs on the pixel clock. It receives horizontal sync, vertical sync and one shared input pin. Depending on the selected scheme, that pin is read either as a data-enable qualifier or as a field identifier. From these inputs the block produces four things: a frame-start pulse, a line-start pulse, an active-pixel qualifier, and a field flag with a one-cycle strobe that marks each new field decision.

Three capture schemes are supported:

- **Progressive.** The scheme relies on VSYNC and the data-enable level. HSYNC plays no part in qualifying pixels.
- **Interlaced with a field pin.** The shared pin is sampled at the start of every field.
- **Interlaced without a field pin.** The field is inferred from sync skew. A vertical sync leading edge that falls on the same clock as a horizontal sync leading edge starts an even field. A vertical sync leading edge that falls anywhere else starts an odd field.

A new scheme selection is adopted only at a vertical sync leading edge, so one frame is never decoded under two schemes.

Top module: `vid_sync_field_dec`

## Requirements
- R1: After reset, every output is low, the field flag reads even (0), and the active scheme is progressive regardless of `mode_i`.
- R2: `frame_start_o` pulses for exactly one cycle for each VSYNC rising edge, two clock edges after the edge where the high level is first sampled. This holds in every scheme.
- R3: `line_start_o` pulses on a rising edge of the shared pin in progressive scheme, and on a rising edge of HSYNC in the two interlaced schemes. The latency is the same as in R2.
- R4: In progressive scheme (`mode_i` = 0, and the unused code 3 behaves the same), `active_o` is high exactly when the shared pin is high and VSYNC is low. HSYNC has no effect on it.
- R5: In the field-pin scheme (`mode_i` = 1) and the skew scheme (`mode_i` = 2), `active_o` is high exactly when both HSYNC and VSYNC are low. The shared pin has no effect on it.
- R6: In skew scheme, a VSYNC rising edge that coincides with an HSYNC rising edge sets `field_odd_o` to 0. `field_valid_o` pulses in the cycle after `frame_start_o`, and the flag changes in that same cycle.
- R7: In skew scheme, a VSYNC rising edge with no coinciding HSYNC rising edge sets `field_odd_o` to 1, with the same timing as R6.
- R8: In field-pin scheme, the shared pin is sampled together with the VSYNC rising edge, with high meaning odd. The result appears on `field_odd_o` with a `field_valid_o` pulse one cycle after `frame_start_o`, and is held until the next field decision.
- R9: In progressive scheme, `field_valid_o` never pulses, and `field_odd_o` returns to 0 one cycle after `frame_start_o`.
- R10: A change on `mode_i` in the middle of a frame has no effect until the next VSYNC rising edge. From that edge on, the new scheme governs all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Scheme select: 0 progressive, 1 field pin, 2 skew, 3 as progressive |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| de_fld_i | input | 1 | Shared pin: data enable or field identifier |
| frame_start_o | output | 1 | One-cycle pulse at the start of each frame or field |
| line_start_o | output | 1 | One-cycle pulse at the start of each line |
| active_o | output | 1 | Active-pixel qualifier |
| field_odd_o | output | 1 | Current field, 1 = odd |
| field_valid_o | output | 1 | One-cycle strobe when a new field decision is made |

## Verification
Frames are generated in each scheme, and a cycle-accurate behavioural model in the bench is compared against every output on every clock.

- **Skew scheme.** Vertical sync is launched both exactly on a horizontal sync leading edge and ten cycles after it. This separates the even decision from the odd one.
- **Field-pin scheme.** Frames are run with the pin held high and held low. This shows the pin's level, and not the sync alignment, sets the flag.
- **Progressive scheme.** Frames use misaligned syncs. In the skew scheme, the shared pin is toggled randomly to show it is ignored.
- **Scheme change.** The selection is switched in the middle of a field-pin frame. This shows the old scheme persists until the next vertical sync.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

    typedef enum logic [1:0] {
        VM_PROG_DE   = 2'd0,
        VM_FIELD_PIN = 2'd1,
        VM_SYNC_SKEW = 2'd2,
        VM_RSVD      = 2'd3
    } vmode_e;

    // Sampled levels of the three sync-side inputs
    typedef struct packed {
        logic hs;
        logic vs;
        logic aux;
    } sync_t;

    // Leading-edge flags, same field order as sync_t
    typedef struct packed {
        logic hs_rise;
        logic vs_rise;
        logic aux_rise;
    } edge_t;

    localparam int SYNC_W = $bits(sync_t);

    function automatic logic is_interlaced(vmode_e m);
        return (m == VM_FIELD_PIN) || (m == VM_SYNC_SKEW);
    endfunction

    function automatic logic field_from_skew(logic hs_rise);
        // coincident edges -> even (0), otherwise odd (1)
        return ~hs_rise;
    endfunction

endpackage

// File: rtl/vsf_sync.sv
module vsf_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vsf_edge.sv
module vsf_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise_o[b] = cur_i[b] & ~prev_q[b];
    end
endmodule

// File: rtl/vsf_field.sv
module vsf_field
    import vsf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   vs_rise_i,
    input  logic   hs_rise_i,
    input  logic   aux_lvl_i,
    input  vmode_e mode_eff_i,
    output logic   field_odd_o,
    output logic   field_valid_o
);
    logic pend_q;      // interlaced field decision waiting to be published
    logic clr_q;       // progressive frame started: force even
    logic odd_next_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            clr_q      <= 1'b0;
            odd_next_q <= 1'b0;
        end else begin
            pend_q <= vs_rise_i & is_interlaced(mode_eff_i);
            clr_q  <= vs_rise_i & ~is_interlaced(mode_eff_i);
            if (vs_rise_i) begin
                if (mode_eff_i == VM_SYNC_SKEW) odd_next_q <= field_from_skew(hs_rise_i);
                else                            odd_next_q <= aux_lvl_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_odd_o   <= 1'b0;
            field_valid_o <= 1'b0;
        end else begin
            field_valid_o <= pend_q;
            if (pend_q)     field_odd_o <= odd_next_q;
            else if (clr_q) field_odd_o <= 1'b0;
        end
    end

    // R8: between decisions the flag only moves when a progressive frame clears it
    a_r8_hold_between_starts: assert property (@(posedge clk) disable iff (rst)
        (!field_valid_o && !$stable(field_odd_o)) |-> !field_odd_o);

endmodule

// File: rtl/vid_sync_field_dec.sv
module vid_sync_field_dec
    import vsf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       hsync_i,
    input  logic       vsync_i,
    input  logic       de_fld_i,
    output logic       frame_start_o,
    output logic       line_start_o,
    output logic       active_o,
    output logic       field_odd_o,
    output logic       field_valid_o
);
    sync_t  raw, syn;
    edge_t  edg;
    vmode_e mode_q, mode_eff;
    logic   uses_de;

    assign raw = '{hs: hsync_i, vs: vsync_i, aux: de_fld_i};

    vsf_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (syn)
    );

    vsf_edge #(.W(SYNC_W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (syn),
        .rise_o (edg)
    );

    // Scheme is adopted only at a frame boundary
    always_comb mode_eff = edg.vs_rise ? vmode_e'(mode_i) : mode_q;
    assign uses_de = ~is_interlaced(mode_eff);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= VM_PROG_DE;
        else     mode_q <= mode_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start_o <= 1'b0;
            line_start_o  <= 1'b0;
            active_o      <= 1'b0;
        end else begin
            frame_start_o <= edg.vs_rise;
            line_start_o  <= uses_de ? edg.aux_rise : edg.hs_rise;
            active_o      <= uses_de ? (syn.aux & ~syn.vs) : (~syn.hs & ~syn.vs);
        end
    end

    vsf_field u_field (
        .clk           (clk),
        .rst           (rst),
        .vs_rise_i     (edg.vs_rise),
        .hs_rise_i     (edg.hs_rise),
        .aux_lvl_i     (syn.aux),
        .mode_eff_i    (mode_eff),
        .field_odd_o   (field_odd_o),
        .field_valid_o (field_valid_o)
    );

    // R2: frame start is a single-cycle pulse
    a_r2_fs_single: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);

    // R4/R5: vertical sync is high at a frame start, so no pixel is active
    a_r4_blank_at_frame: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> !active_o);

    // R6: a field decision follows a frame start by one cycle
    a_r6_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        field_valid_o |-> $past(frame_start_o));

    // R9: no field decision under progressive scheme
    a_r9_prog_no_valid: assert property (@(posedge clk) disable iff (rst)
        field_valid_o |-> is_interlaced(mode_q));

    // R10: scheme register moves only at a vertical sync leading edge
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !edg.vs_rise |=> $stable(mode_q));

endmodule

// File: tb/vid_sync_field_dec_test.sv
`timescale 1ns/1ps
module vid_sync_field_dec_test;

    localparam int LINE  = 24;
    localparam int NLINE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic       hsync_i = 1'b0, vsync_i = 1'b0, de_fld_i = 1'b0;
    logic       frame_start_o, line_start_o, active_o, field_odd_o, field_valid_o;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;
    bit  r10_win = 0;

    always #2.5 clk = ~clk;

    vid_sync_field_dec uut (
        .clk (clk), .rst (rst), .mode_i (mode_i),
        .hsync_i (hsync_i), .vsync_i (vsync_i), .de_fld_i (de_fld_i),
        .frame_start_o (frame_start_o), .line_start_o (line_start_o),
        .active_o (active_o), .field_odd_o (field_odd_o),
        .field_valid_o (field_valid_o)
    );

    // ---------------- behavioural reference ----------------
    logic hh [4], vh [4], ph [4];     // index 0 = newest edge sample
    int   m_mode;
    logic e_fs, e_ls, e_act, e_odd, e_fv;
    logic pend, pend_odd, pend_clr;

    function automatic bit interl(int m);
        return (m == 1) || (m == 2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin hh[i] = 0; vh[i] = 0; ph[i] = 0; end
            m_mode = 0; e_fs = 0; e_ls = 0; e_act = 0; e_odd = 0; e_fv = 0;
            pend = 0; pend_odd = 0; pend_clr = 0;
        end else begin
            logic vr, hr, pr;
            for (int i = 3; i > 0; i--) begin hh[i] = hh[i-1]; vh[i] = vh[i-1]; ph[i] = ph[i-1]; end
            hh[0] = hsync_i; vh[0] = vsync_i; ph[0] = de_fld_i;
            // outputs after this edge reflect samples taken two edges earlier
            vr = vh[2] & ~vh[3];
            hr = hh[2] & ~hh[3];
            pr = ph[2] & ~ph[3];
            // field stage uses the decision made one edge ago
            e_fv = pend;
            if (pend) e_odd = pend_odd;
            else if (pend_clr) e_odd = 0;
            if (vr) m_mode = int'(mode_i);
            e_fs  = vr;
            e_ls  = interl(m_mode) ? hr : pr;
            e_act = interl(m_mode) ? (~hh[2] & ~vh[2]) : (ph[2] & ~vh[2]);
            pend     = vr & interl(m_mode);
            pend_clr = vr & ~interl(m_mode);
            if (vr) pend_odd = (m_mode == 2) ? ~hr : ph[2];
        end
    end

    function automatic string tag_for(string base);
        return r10_win ? {"R10/", base} : base;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // compare every output every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            string fr;
            chk(tag_for("R2"), frame_start_o, e_fs);
            chk(tag_for("R3"), line_start_o, e_ls);
            chk(tag_for(interl(m_mode) ? "R5" : "R4"), active_o, e_act);
            if (m_mode == 2)      fr = e_odd ? "R7" : "R6";
            else if (m_mode == 1) fr = "R8";
            else                  fr = "R9";
            chk(tag_for(fr), field_odd_o, e_odd);
            chk(tag_for(fr), field_valid_o, e_fv);
        end
    end

    // ---------------- stimulus ----------------
    // kind: 0 progressive data, 1 field pin level fpin, 2 skew with pin noise
    task automatic frame(input logic [1:0] m, input int kind, input bit align,
                         input bit fpin, input int sw_line, input logic [1:0] m_next);
        int vpos;
        vpos = align ? 0 : 10;
        for (int l = 0; l < NLINE; l++) begin
            for (int p = 0; p < LINE; p++) begin
                @(negedge clk);
                if (l == 0 && p == 0) mode_i = m;
                if (l == sw_line && p == 0) mode_i = m_next;
                hsync_i = (p < 4);
                vsync_i = (l == 0 && p >= vpos) || (l == 1) || (l == 2 && p < vpos);
                case (kind)
                    0:       de_fld_i = (l >= 3) && (p >= 6) && (p < 20);
                    1:       de_fld_i = fpin;
                    default: de_fld_i = 1'($urandom_range(0, 1));
                endcase
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, progressive scheme even though mode_i may differ
        chk("R1", frame_start_o, 1'b0);
        chk("R1", active_o, 1'b0);
        chk("R1", field_odd_o, 1'b0);
        chk("R1", field_valid_o, 1'b0);
        mode_i = 2'd2;
        repeat (5) @(negedge clk);
        chk("R1", line_start_o, 1'b0);

        frame(2'd0, 0, 1'b0, 1'b0, -1, 2'd0);   // R4 progressive
        frame(2'd0, 0, 1'b1, 1'b0, -1, 2'd0);
        frame(2'd2, 2, 1'b1, 1'b0, -1, 2'd0);   // R6 aligned -> even
        frame(2'd2, 2, 1'b0, 1'b0, -1, 2'd0);   // R7 skewed -> odd
        frame(2'd2, 2, 1'b1, 1'b0, -1, 2'd0);
        frame(2'd1, 1, 1'b0, 1'b1, -1, 2'd0);   // R8 pin high -> odd
        frame(2'd1, 1, 1'b1, 1'b0, -1, 2'd0);   // R8 pin low -> even, aligned
        frame(2'd1, 1, 1'b1, 1'b1, -1, 2'd0);
        frame(2'd0, 0, 1'b0, 1'b0, -1, 2'd0);   // R9 clears to even
        r10_win = 1;                             // R10 mid-frame switch
        frame(2'd1, 1, 1'b0, 1'b1, 4, 2'd2);
        frame(2'd2, 2, 1'b1, 1'b0, 4, 2'd0);
        r10_win = 0;
        frame(2'd0, 0, 1'b0, 1'b0, -1, 2'd0);
        frame(2'd3, 0, 1'b1, 1'b0, -1, 2'd0);   // R4 code 3 as progressive
        repeat (6) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule